// File: doc/BRIEF.md
# One-Shot Reseedable Pseudo-Random Generator with Serial Seed Port

This block runs a 24-bit Fibonacci pseudo-random sequence in the system clock domain and lets an external serial master supply a replacement start value exactly once. The serial side is a slave port clocked by the master's own serial clock, about 4 MHz. Each write frame carries three bytes, sent most significant bit first. The generator side runs on a clock that has no fixed relation to the serial clock.

Nothing combinational joins the two domains. When a frame completes, the serial side freezes the received word in a holding register and flips a single toggle bit. The system side passes that bit through a two-flop synchronizer and uses the detected edge to copy the frozen word into a staging register of its own. The generator load mux only ever sees this staging register or the constant seed, so a shift in progress, or a glitch on the serial clock, cannot reach the running sequence.

A small controller sets the load order. It has five states:
- SEED: the first cycle after reset, in which the constant seed is written.
- IDLE: the generator runs.
- ARMED: a load was requested before any word had arrived.
- LOAD: the single cycle that writes the staged word.
- DONE: terminal until reset.

Its transitions are:
- SEED→IDLE: always.
- IDLE→LOAD: on a request when a staged word exists.
- IDLE→ARMED: on a request when no staged word exists.
- ARMED→LOAD: when the first word is staged.
- LOAD→DONE: always.
- DONE→DONE: always.

Top module: `lfsr_spi_loader`

## Requirements
- R1: While `rst_n` is low, `lfsr_q` is 0 and `reseeded` is 0. On the first `clk` edge after release, `lfsr_q` becomes the seed (default 24'hC0FFEE), whatever the value of `step_en`.
- R2: In IDLE, ARMED or DONE, a `clk` edge with `step_en` high makes `lfsr_q` equal to `{q[22:0], q[23]^q[22]^q[21]^q[16]}`, where q is the previous value. With `step_en` low, `lfsr_q` holds.
- R3: A serial frame is 24 bits. `mosi` is sampled on rising `sck` while `cs_n` is low, and the first bit sampled becomes bit 23 of the word.
- R4: A frame that ends with `cs_n` going high before the 24th bit delivers no word, and it cannot satisfy a pending load.
- R5: A `load_req` sampled high in IDLE, when a word has been staged, writes the staged word into `lfsr_q` on the following `clk` edge. `reseeded` rises on that same edge.
- R6: A `load_req` sampled before any word has been staged is remembered. The first complete frame received afterwards is then loaded.
- R7: A staged word of all zeros loads the seed instead, so `lfsr_q` is never zero after a load.
- R8: Once `reseeded` is 1, it stays 1 until reset. Later frames and later `load_req` pulses leave `lfsr_q` unchanged apart from R2 stepping.
- R9: On the edge that writes the staged word, `step_en` has no effect: `lfsr_q` equals the loaded value, not a stepped one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of the generator domain |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| sck | input | 1 | Serial clock from the external master |
| cs_n | input | 1 | Active-low frame select; high abandons a partial frame |
| mosi | input | 1 | Serial data from the master, MSB first |
| step_en | input | 1 | Advance the generator one step per cycle |
| load_req | input | 1 | Request the one-time load of the received word |
| lfsr_q | output | 24 | Current generator state |
| reseeded | output | 1 | The one-time load has happened |

## Verification
A controller stuck in, or skipping, a state shows on `lfsr_q` within one `clk` cycle. Examples are a missed seed cycle, a stepped value on the load edge, or a second load after DONE. It also shows on `reseeded` on the same edge. A fault on the serial side shows as a wrong loaded value: a bit-order error, or a word taken from an abandoned frame. This is visible a few cycles after the synchronizer delay, because the loaded value is compared word-for-word against the value the bench sent. Stepping is checked every cycle against an independent model, so a wrong tap shows at the first stepped cycle.

// File: rtl/lsl_pkg.sv
package lsl_pkg;

    typedef enum logic [2:0] {
        ST_SEED  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_ARMED = 3'd2,
        ST_LOAD  = 3'd3,
        ST_DONE  = 3'd4
    } ldr_state_t;

endpackage

// File: rtl/spi_word_rx.sv
module spi_word_rx #(
    parameter int W = 24
) (
    input  logic         sck,
    input  logic         cs_n,
    input  logic         mosi,
    input  logic         rst_n,
    output logic [W-1:0] word_o,
    output logic         tgl_o
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     shreg;

    // Bit counter: a high frame select abandons any partial frame.
    always_ff @(posedge sck or posedge cs_n or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (cs_n) begin
            bit_cnt <= '0;
        end else if (bit_cnt == LAST) begin
            bit_cnt <= '0;
        end else begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Shift path, frozen holding word and completion toggle.
    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            word_o <= '0;
            tgl_o  <= 1'b0;
        end else if (!cs_n) begin
            shreg <= {shreg[W-2:0], mosi};
            if (bit_cnt == LAST) begin
                word_o <= {shreg[W-2:0], mosi};
                tgl_o  <= ~tgl_o;
            end
        end
    end

endmodule

// File: rtl/toggle_sync.sv
module toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic pulse_o
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its history.
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], tgl_i};
        end
    end

    assign pulse_o = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/word_stage.sv
module word_stage #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o,
    output logic         valid_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else if (capture_i) begin
            word_o  <= word_i;
            valid_o <= 1'b1;
        end
    end

endmodule

// File: rtl/lfsr_load_ctrl.sv
module lfsr_load_ctrl
    import lsl_pkg::*;
#(
    parameter int         W        = 24,
    parameter logic [W-1:0] SEED     = 24'hC0FFEE,
    parameter logic [W-1:0] TAP_MASK = 24'hE10000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         load_req,
    input  logic         word_valid,
    input  logic [W-1:0] staged_word,
    output ldr_state_t   state_o,
    output logic [W-1:0] lfsr_o,
    output logic         done_o
);
    ldr_state_t   state_q, state_d;
    logic         load_now;
    logic         advance;
    logic [W-1:0] load_val;
    logic [W-1:0] step_val;

    function automatic logic [W-1:0] lfsr_step(input logic [W-1:0] q);
        return {q[W-2:0], ^(q & TAP_MASK)};
    endfunction

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEED:  state_d = ST_IDLE;
            ST_IDLE:  if (load_req) state_d = word_valid ? ST_LOAD : ST_ARMED;
            ST_ARMED: if (word_valid) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_SEED;
        endcase
    end

    // Output decode: two-input load mux (seed or staged word) and step enable.
    always_comb begin
        load_now = 1'b0;
        advance  = 1'b0;
        load_val = SEED;
        unique case (state_q)
            ST_SEED: begin
                load_now = 1'b1;
                load_val = SEED;
            end
            ST_LOAD: begin
                load_now = 1'b1;
                load_val = (staged_word == '0) ? SEED : staged_word;
            end
            ST_IDLE, ST_ARMED, ST_DONE: advance = step_en;
            default: load_now = 1'b0;
        endcase
    end

    assign step_val = lfsr_step(lfsr_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_o <= '0;
        end else if (load_now) begin
            lfsr_o <= load_val;
        end else if (advance) begin
            lfsr_o <= step_val;
        end
    end

    assign done_o  = (state_q == ST_DONE);
    assign state_o = state_q;

endmodule

// File: rtl/lfsr_spi_loader.sv
module lfsr_spi_loader
    import lsl_pkg::*;
#(
    parameter int           WORD_W      = 24,
    parameter int           SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] SEED     = 24'hC0FFEE,
    parameter logic [WORD_W-1:0] TAP_MASK = 24'hE10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              step_en,
    input  logic              load_req,
    output logic [WORD_W-1:0] lfsr_q,
    output logic              reseeded
);
    logic [WORD_W-1:0] held_word;
    logic              frame_tgl;
    logic              frame_pulse;
    logic              capture;
    logic [WORD_W-1:0] staged_word;
    logic              staged_valid;
    ldr_state_t        ctl_state;

    spi_word_rx #(.W(WORD_W)) u_rx (
        .sck    (sck),
        .cs_n   (cs_n),
        .mosi   (mosi),
        .rst_n  (rst_n),
        .word_o (held_word),
        .tgl_o  (frame_tgl)
    );

    toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgl_i   (frame_tgl),
        .pulse_o (frame_pulse)
    );

    assign capture = frame_pulse & ~reseeded;

    word_stage #(.W(WORD_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .word_i    (held_word),
        .word_o    (staged_word),
        .valid_o   (staged_valid)
    );

    lfsr_load_ctrl #(
        .W        (WORD_W),
        .SEED     (SEED),
        .TAP_MASK (TAP_MASK)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .load_req    (load_req),
        .word_valid  (staged_valid),
        .staged_word (staged_word),
        .state_o     (ctl_state),
        .lfsr_o      (lfsr_q),
        .done_o      (reseeded)
    );

endmodule

// File: rtl/lsl_checker.sv
module lsl_checker
    import lsl_pkg::*;
#(
    parameter int           W        = 24,
    parameter logic [W-1:0] SEED     = 24'hC0FFEE,
    parameter logic [W-1:0] TAP_MASK = 24'hE10000
) (
    input logic         clk,
    input logic         rst_n,
    input logic         step_en,
    input logic         load_req,
    input logic         word_valid,
    input logic [W-1:0] lfsr_q,
    input logic         reseeded,
    input ldr_state_t   state
);
    function automatic logic [W-1:0] ref_step(input logic [W-1:0] q);
        logic fb;
        fb = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (TAP_MASK[i]) fb = fb ^ q[i];
        end
        return {q[W-2:0], fb};
    endfunction

    logic running;
    assign running = (state == ST_IDLE) || (state == ST_ARMED) || (state == ST_DONE);

    a_r1_seed_written: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEED) |=> (lfsr_q == SEED));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !step_en) |=> $stable(lfsr_q));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step_en) |=> (lfsr_q == ref_step($past(lfsr_q))));

    a_r5_request_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && load_req && word_valid) |=> (state == ST_LOAD));

    a_r7_nonzero_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (reseeded && lfsr_q != '0));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        reseeded |=> reseeded);

endmodule

bind lfsr_spi_loader lsl_checker #(
    .W        (WORD_W),
    .SEED     (SEED),
    .TAP_MASK (TAP_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .load_req   (load_req),
    .word_valid (staged_valid),
    .lfsr_q     (lfsr_q),
    .reseeded   (reseeded),
    .state      (ctl_state)
);

// File: tb/lfsr_spi_loader_bench.sv
`timescale 1ns/1ps
module lfsr_spi_loader_bench;
    localparam logic [23:0] SEED = 24'hC0FFEE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        step_en = 1'b0;
    logic        load_req = 1'b0;
    logic [23:0] lfsr_q;
    logic        reseeded;

    int checks = 0;
    int failures = 0;
    logic [23:0] model;
    logic [23:0] exp_q[$];
    string       tag_q[$];
    bit          ended = 1'b0;

    always #4 clk = ~clk;

    lfsr_spi_loader u_lfsr_spi_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .step_en  (step_en),
        .load_req (load_req),
        .lfsr_q   (lfsr_q),
        .reseeded (reseeded)
    );

    function automatic logic [23:0] nstep(input logic [23:0] q);
        return {q[22:0], q[23] ^ q[22] ^ q[21] ^ q[16]};
    endfunction

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected value for this cycle.
    task automatic expect_lfsr(input logic [23:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares one expected item per cycle, just after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), lfsr_q, exp_q.pop_front());
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; step_en = 1'b0; load_req = 1'b0; cs_n = 1'b1; sck = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset lfsr", lfsr_q, 24'h0);
        check("R1 reset flag", {23'h0, reseeded}, 24'h0);
        step_en = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        model = SEED;
        expect_lfsr(model, "R1 seed after reset");
        step_en = 1'b0;
    endtask

    task automatic send_frame(input logic [23:0] w, input int nbits);
        cs_n = 1'b0;
        #60;
        for (int i = 0; i < nbits; i++) begin
            mosi = w[23 - i];
            #125 sck = 1'b1;
            #125 sck = 1'b0;
        end
        #60 cs_n = 1'b1;
        #200;
    endtask

    task automatic run_steps(input int n, input logic en);
        step_en = en;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (en) model = nstep(model);
            expect_lfsr(model, en ? "R2 step" : "R2 hold");
        end
        step_en = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    initial begin
        // Scenario A: seed, stepping, request before any word, aborted frame.
        do_reset();
        run_steps(30, 1'b1);
        run_steps(5, 1'b0);
        pulse_req();
        send_frame(24'hFFF000, 10);                 // R4 abandoned frame
        repeat (20) @(negedge clk);
        check("R4 no load from partial frame", lfsr_q, model);
        check("R4 flag still low", {23'h0, reseeded}, 24'h0);
        send_frame(24'h5A3C96, 24);                 // R6 armed load
        repeat (20) @(negedge clk);
        check("R6 armed request loads first frame", lfsr_q, 24'h5A3C96);
        check("R3 msb-first order", lfsr_q, 24'h5A3C96);
        check("R6 flag set", {23'h0, reseeded}, 24'h1);

        // Scenario B: idle request with staged word, stepping around the load.
        do_reset();
        send_frame(24'h1234AB, 24);
        repeat (10) @(negedge clk);
        run_steps(8, 1'b1);
        step_en = 1'b1;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        model = nstep(model);
        expect_lfsr(model, "R5 step on request cycle");
        @(negedge clk);
        model = 24'h1234AB;
        expect_lfsr(model, "R9 load ignores step_en");
        #2;
        check("R5 flag with load", {23'h0, reseeded}, 24'h1);
        @(negedge clk);
        model = nstep(model);
        expect_lfsr(model, "R2 step after load");
        step_en = 1'b0;
        @(negedge clk);
        expect_lfsr(model, "R2 hold after load");
        send_frame(24'h00FF00, 24);                 // R8 later frame
        pulse_req();
        repeat (20) @(negedge clk);
        check("R8 no second load", lfsr_q, model);
        check("R8 flag sticky", {23'h0, reseeded}, 24'h1);
        run_steps(4, 1'b1);

        // Scenario C: zero word loads the seed.
        do_reset();
        run_steps(3, 1'b1);
        send_frame(24'h000000, 24);
        repeat (10) @(negedge clk);
        pulse_req();
        repeat (5) @(negedge clk);
        check("R7 zero word replaced by seed", lfsr_q, SEED);
        check("R7 flag set", {23'h0, reseeded}, 24'h1);

        repeat (4) @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule